// File: doc/BRIEF.md
# Integrator Offset Nulling Tracker

This block keeps a digital code for the converter's offset-compensation DAC, so that integrator offset cannot stop the small rundown slopes from reaching zero. A phase indicator from the sequencer, raised before the one-hundredth-current phase, switches the DAC output on. A conversion-end pulse switches it off. The code itself is kept from one conversion to the next.

The code is adjusted during the last rundown phase. In that phase the smallest positive and negative currents alternate. They have equal magnitude, so with no offset each interval reaches its comparator crossing after the same time. The block counts ALE strobes from each polarity switch to the crossing pulse that follows it. When it holds one positive and one negative duration, it compares them. If the gap is larger than one five-strobe unit, it moves the code one LSB in the direction that shortens the longer interval. The error term is therefore a difference in time, not a sampled voltage.

Top module: `offset_null_tracker`

## Requirements
- R1: While reset is high, and in the first cycle after it, `dac_code` is 128 (midscale) and `dac_en` is 0.
- R2: `dac_en` is 1 in the cycle after `arm_null` is sampled high and stays 1 until `conv_end` is sampled high. It is 0 in the cycle after that. `conv_end` wins when both are high in the same cycle.
- R3: An interval starts at `pol_strobe` (polarity from `pol_pos`: 1 = positive, 0 = negative). Its length is the number of `ale_en` cycles seen from that strobe up to the `zc_pulse` that ends it. The count saturates at 255.
- R4: When a pair is complete and the positive length exceeds the negative length by more than 5, `dac_code` rises by one in the cycle after the crossing pulse.
- R5: When a pair is complete and the negative length exceeds the positive length by more than 5, `dac_code` falls by one in the cycle after the crossing pulse.
- R6: When the two lengths differ by 5 or less, `dac_code` is left unchanged. The measurements may come in either order: positive first or negative first.
- R7: `dac_code` stops at 255 going up and at 0 going down. It never wraps.
- R8: While `alt_phase` is low, strobes, ALE cycles and crossing pulses have no effect on `dac_code`. Any half-collected pair is discarded.
- R9: `dac_code` changes only at the completion of a pair, and by at most one step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ale_en | input | 1 | One-cycle ALE strobe, the unit of interval time |
| arm_null | input | 1 | Sequencer indicator raised before the one-hundredth-current phase |
| conv_end | input | 1 | End-of-conversion pulse, turns the DAC output off |
| alt_phase | input | 1 | High during the alternating smallest-current phase |
| pol_strobe | input | 1 | Polarity switch pulse; starts an interval |
| pol_pos | input | 1 | Polarity applied at `pol_strobe`: 1 positive, 0 negative |
| zc_pulse | input | 1 | Comparator zero-crossing pulse; ends an interval |
| dac_code | output | 8 | Offset-compensation DAC code |
| dac_en | output | 1 | DAC output enable |

## Verification
Two conditions are hard to reach from the ports: the code resting at either rail, and the counter saturating. The stimulus reaches the rails by repeating short, strongly unbalanced pairs more than 128 times in each direction. After each run it checks that the code stays pinned there. Saturation is reached with a positive interval of 300 ALE strobes paired with a negative one of 250. Only a counter that stops at 255 leaves the gap inside the dead band. A counter that wraps would give a gap outside it and step the code.

// File: rtl/offset_null_pkg.sv
package offset_null_pkg;

    localparam int ONP_CODE_W   = 8;
    localparam int ONP_CNT_W    = 8;
    localparam int ONP_DEADBAND = 5;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Decide the step from the two interval lengths.
    function automatic step_e judge_pair(input int pos_len, input int neg_len, input int band);
        if (pos_len - neg_len > band)      return STEP_UP;
        else if (neg_len - pos_len > band) return STEP_DOWN;
        else                               return STEP_HOLD;
    endfunction

    // Apply a step with clamping at both rails.
    function automatic int apply_step(input int code, input step_e st, input int code_max);
        case (st)
            STEP_UP:   return (code >= code_max) ? code_max : code + 1;
            STEP_DOWN: return (code <= 0) ? 0 : code - 1;
            default:   return code;
        endcase
    endfunction

endpackage

// File: rtl/interval_timer.sv
module interval_timer #(
    parameter int CNT_W = offset_null_pkg::ONP_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic             start,
    input  logic             start_pos,
    input  logic             tick,
    input  logic             hit,
    output logic             done,
    output logic             done_pos,
    output logic [CNT_W-1:0] done_len
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             running;
    logic             pol_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            running <= 1'b0;
            pol_q   <= 1'b0;
            cnt_q   <= '0;
        end else if (start) begin
            running <= 1'b1;
            pol_q   <= start_pos;
            cnt_q   <= '0;
        end else if (running && hit) begin
            running <= 1'b0;
        end else if (running && tick && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done     = active && running && hit && !start;
    assign done_pos = pol_q;
    assign done_len = cnt_q;
endmodule

// File: rtl/pair_judge.sv
module pair_judge #(
    parameter int CNT_W    = offset_null_pkg::ONP_CNT_W,
    parameter int CODE_W   = offset_null_pkg::ONP_CODE_W,
    parameter int DEADBAND = offset_null_pkg::ONP_DEADBAND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              done,
    input  logic              done_pos,
    input  logic [CNT_W-1:0]  done_len,
    output logic [CODE_W-1:0] dac_code
);
    import offset_null_pkg::*;

    localparam int                CODE_MAX = (1 << CODE_W) - 1;
    localparam logic [CODE_W-1:0] CODE_MID = CODE_W'(1 << (CODE_W - 1));

    logic [CNT_W-1:0]  pos_len_q, neg_len_q;
    logic              have_pos, have_neg;
    logic [CNT_W-1:0]  pos_v, neg_v;
    logic              pair_full;
    step_e             step;
    logic [CODE_W-1:0] code_next;

    always_comb begin
        pos_v     = done_pos ? done_len : pos_len_q;
        neg_v     = done_pos ? neg_len_q : done_len;
        pair_full = done_pos ? have_neg : have_pos;
        step      = judge_pair(int'(pos_v), int'(neg_v), DEADBAND);
        code_next = CODE_W'(apply_step(int'(dac_code), step, CODE_MAX));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dac_code  <= CODE_MID;
            pos_len_q <= '0;
            neg_len_q <= '0;
            have_pos  <= 1'b0;
            have_neg  <= 1'b0;
        end else if (!active) begin
            have_pos <= 1'b0;
            have_neg <= 1'b0;
        end else if (done) begin
            if (pair_full) begin
                dac_code <= code_next;
                have_pos <= 1'b0;
                have_neg <= 1'b0;
            end else if (done_pos) begin
                pos_len_q <= done_len;
                have_pos  <= 1'b1;
            end else begin
                neg_len_q <= done_len;
                have_neg  <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/offset_null_tracker.sv
module offset_null_tracker #(
    parameter int CNT_W    = offset_null_pkg::ONP_CNT_W,
    parameter int CODE_W   = offset_null_pkg::ONP_CODE_W,
    parameter int DEADBAND = offset_null_pkg::ONP_DEADBAND
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ale_en,
    input  logic              arm_null,
    input  logic              conv_end,
    input  logic              alt_phase,
    input  logic              pol_strobe,
    input  logic              pol_pos,
    input  logic              zc_pulse,
    output logic [CODE_W-1:0] dac_code,
    output logic              dac_en
);
    logic             meas_done;
    logic             meas_pos;
    logic [CNT_W-1:0] meas_len;

    always_ff @(posedge clk) begin
        if (rst || conv_end) dac_en <= 1'b0;
        else if (arm_null)   dac_en <= 1'b1;
    end

    interval_timer #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .active    (alt_phase),
        .start     (pol_strobe),
        .start_pos (pol_pos),
        .tick      (ale_en),
        .hit       (zc_pulse),
        .done      (meas_done),
        .done_pos  (meas_pos),
        .done_len  (meas_len)
    );

    pair_judge #(.CNT_W(CNT_W), .CODE_W(CODE_W), .DEADBAND(DEADBAND)) u_judge (
        .clk      (clk),
        .rst      (rst),
        .active   (alt_phase),
        .done     (meas_done),
        .done_pos (meas_pos),
        .done_len (meas_len),
        .dac_code (dac_code)
    );
endmodule

// File: rtl/offset_null_checker.sv
module offset_null_checker #(
    parameter int CODE_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              arm_null,
    input logic              conv_end,
    input logic              alt_phase,
    input logic [CODE_W-1:0] dac_code,
    input logic              dac_en
);
    localparam logic [CODE_W-1:0] MID = CODE_W'(1 << (CODE_W - 1));
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    logic live;
    always_ff @(posedge clk) live <= !rst;

    AST_RESET_MID: assert property (@(posedge clk) rst |=> (dac_code == MID && !dac_en)); // R1
    AST_EN_ON: assert property (@(posedge clk) disable iff (rst) (arm_null && !conv_end) |=> dac_en); // R2
    AST_EN_OFF: assert property (@(posedge clk) disable iff (rst) conv_end |=> !dac_en); // R2
    AST_NO_WRAP_UP: assert property (@(posedge clk) disable iff (rst) (dac_code == TOP) |=> (dac_code != '0)); // R7
    AST_NO_WRAP_DN: assert property (@(posedge clk) disable iff (rst) (dac_code == '0) |=> (dac_code != TOP)); // R7
    AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (rst) !alt_phase |=> $stable(dac_code)); // R8
    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst) live |-> (dac_code == $past(dac_code) || dac_code == $past(dac_code) + 1'b1 || dac_code == $past(dac_code) - 1'b1)); // R9
endmodule

bind offset_null_tracker offset_null_checker #(.CODE_W(CODE_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .arm_null  (arm_null),
    .conv_end  (conv_end),
    .alt_phase (alt_phase),
    .dac_code  (dac_code),
    .dac_en    (dac_en)
);

// File: tb/sim_offset_null_tracker.sv
module sim_offset_null_tracker;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ale_en = 0, arm_null = 0, conv_end = 0, alt_phase = 0;
    logic       pol_strobe = 0, pol_pos = 0, zc_pulse = 0;
    logic [7:0] dac_code;
    logic       dac_en;
    int         n_cmp = 0;
    int         n_bad = 0;
    int         exp_code;

    always #10 clk = ~clk;

    offset_null_tracker u0 (
        .clk(clk), .rst(rst), .ale_en(ale_en), .arm_null(arm_null),
        .conv_end(conv_end), .alt_phase(alt_phase), .pol_strobe(pol_strobe),
        .pol_pos(pol_pos), .zc_pulse(zc_pulse), .dac_code(dac_code), .dac_en(dac_en)
    );

    // {positive length, negative length, negative first, expected step}
    localparam int NVEC = 9;
    localparam int VEC [NVEC][4] = '{
        '{20, 10, 0,  1},
        '{10, 20, 0, -1},
        '{15, 10, 0,  0},
        '{16, 10, 1,  1},
        '{10, 16, 0, -1},
        '{ 0,  0, 0,  0},
        '{40, 35, 1,  0},
        '{ 3, 30, 1, -1},
        '{ 9,  2, 1,  1}
    };

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic interval(input logic pos, input int n);
        pol_pos    = pos;
        pol_strobe = 1'b1;
        @(negedge clk);
        pol_strobe = 1'b0;
        for (int i = 0; i < n; i++) begin
            ale_en = 1'b1;
            @(negedge clk);
            ale_en = 1'b0;
            @(negedge clk);
        end
        zc_pulse = 1'b1;
        @(negedge clk);
        zc_pulse = 1'b0;
    endtask

    task automatic pair(input int p, input int n, input bit neg_first);
        if (neg_first) begin interval(1'b0, n); interval(1'b1, p); end
        else           begin interval(1'b1, p); interval(1'b0, n); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 code", dac_code, 128);
        check("R1 en", dac_en, 0);

        arm_null = 1'b1; @(negedge clk); arm_null = 1'b0;
        check("R2 enable", dac_en, 1);

        alt_phase = 1'b1;
        exp_code  = 128;
        for (int v = 0; v < NVEC; v++) begin
            pair(VEC[v][0], VEC[v][1], VEC[v][2] != 0);
            exp_code += VEC[v][3];
            check(VEC[v][3] > 0 ? "R4 step up" : VEC[v][3] < 0 ? "R5 step down" : "R6 dead band",
                  dac_code, exp_code);
        end

        // R3: saturation keeps 300 vs 250 inside dead band
        pair(300, 250, 0);
        check("R3 saturate", dac_code, exp_code);

        // R8: outside alternating phase nothing moves
        alt_phase = 1'b0;
        pair(40, 0, 0);
        check("R8 ignored", dac_code, exp_code);
        // half pair discarded when phase drops
        alt_phase = 1'b1;
        interval(1'b1, 40);
        alt_phase = 1'b0; @(negedge clk); alt_phase = 1'b1;
        interval(1'b0, 0);
        check("R8 discard half", dac_code, exp_code);
        interval(1'b1, 0);
        check("R6 fresh pair", dac_code, exp_code);

        // R7: rails
        for (int k = 0; k < 140; k++) pair(7, 0, 0);
        check("R7 top", dac_code, 255);
        for (int k = 0; k < 270; k++) pair(0, 7, 0);
        check("R7 bottom", dac_code, 0);

        arm_null = 1'b1; conv_end = 1'b1; @(negedge clk);
        arm_null = 1'b0; conv_end = 1'b0;
        check("R2 disable", dac_en, 0);
        check("R9 held", dac_code, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule